// File: doc/BRIEF.md
# Full-Line Write-Invalidate Cache Controller

This block is a top-of-hierarchy, direct-mapped write cache controller. It watches CPU writes and recognises those that cover an entire aligned line while fast writes are enabled. Such a write is turned into a write-invalidate transaction. The line is placed in the local array at once, with its full data, marked dirty and flagged as still able to become exclusive. No read of the old line is made. The transaction is always sent downstream, and the line state is settled when the downstream response returns.

Every other write is a plain write-through. It is forwarded downstream with byte strobes. It updates a cached copy only when that copy is writable, and it drops a valid copy that is not writable. It never allocates a line. A snoop port lets other agents take a shared copy or invalidate a line. Taking a shared copy withdraws the line's claim to exclusivity while its write-invalidate is in flight, so the line then ends Shared instead of Exclusive. A read-only port exposes the status byte, tag and data of any line.

At most one write-invalidate is outstanding at a time. Memory responses return in request order, and each one gives the CPU a single-cycle write response.

Top module: `wrinv_line_cache`

## Requirements
- R1: A write is promoted to write-invalidate (`mem_req_wrinv_o`=1, all strobes set) only when `fast_wr_en_i` is 1, `cpu_req_size_i` equals log2 of the line size (size code n means 2^n bytes) and the address offset within the line is 0. Any other write goes out with `mem_req_wrinv_o`=0 and strobes set exactly for the 2^n bytes starting at the offset.
- R2: The status byte encodes valid in bit 0, writable in bit 1, readable in bit 2, dirty in bit 3 and can-go-exclusive in bit 7. On the cycle after a promoted write is accepted, the indexed line reads 0x8D, with the request's tag and full data.
- R3: Each accepted write produces exactly one memory request, valid from the cycle after acceptance. Its address and data stay stable while `mem_req_ready_i` is low.
- R4: A full-line write is refused (ready low, nothing forwarded) while a write-invalidate is outstanding or while the indexed line is dirty.
- R5: When the write-invalidate response arrives, the line becomes 0x07 (clean exclusive) if its can-go-exclusive bit is still set, and 0x05 (clean shared) if a snoop cleared that bit.
- R6: A snoop read that hits (valid line, same tag) clears writable and can-go-exclusive. A snoop invalidate that hits clears the whole status byte. A snoop with a different tag has no effect.
- R7: A plain write that hits a line whose can-go-exclusive bit is set is refused and raises `wi_hold_o`. Plain writes to other lines are still accepted. `wi_hold_o` is low from the cycle after the write-invalidate response, and the stalled write is then accepted.
- R8: Every memory response produces a one-cycle `cpu_rsp_valid_o` on the following cycle.
- R9: If the line was invalidated before its write-invalidate response, the response leaves its status unchanged.
- R10: A plain write that hits a writable line merges its strobed bytes into the cached data and leaves the status unchanged. A hit on a valid, non-writable line invalidates it (status 0x00). A miss leaves the array untouched.
- R11: After reset every status byte is 0x00, and `wi_hold_o`, `mem_req_valid_o` and `cpu_rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fast_wr_en_i | input | 1 | Allows promotion of full-line writes |
| cpu_req_valid_i | input | 1 | CPU write request valid |
| cpu_req_ready_o | output | 1 | CPU write request accepted this cycle |
| cpu_req_addr_i | input | ADDR_W | Byte address |
| cpu_req_size_i | input | SZ_W | log2 of the byte count |
| cpu_req_data_i | input | 8*LINE_BYTES | Write data in byte lanes |
| cpu_rsp_valid_o | output | 1 | Write response pulse |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_wrinv_o | output | 1 | 1 = write-invalidate, 0 = plain write |
| mem_req_addr_o | output | ADDR_W | Request address |
| mem_req_data_o | output | 8*LINE_BYTES | Request data |
| mem_req_strb_o | output | LINE_BYTES | Byte strobes |
| mem_rsp_valid_i | input | 1 | In-order memory response |
| snp_valid_i | input | 1 | Snoop valid |
| snp_inv_i | input | 1 | 1 = invalidate, 0 = shared read |
| snp_addr_i | input | ADDR_W | Snoop address |
| wi_hold_o | output | 1 | A request is being stalled by a pending write-invalidate |
| stat_idx_i | input | IDX_W | Line select for status read |
| stat_o | output | 8 | Status byte of selected line |
| stat_tag_o | output | TAG_W | Tag of selected line |
| stat_data_o | output | 8*LINE_BYTES | Data of selected line |

## Verification
The hardest case to reach is a snoop that lands in the window between a line's allocation and its write-invalidate response. The same window matters for a plain write that meets the line while it is still owned-dirty. The bench holds back the memory response by hand so that these events fall inside the window. It injects snoop reads, snoop invalidates and stalled plain writes there, then releases the response while a stalled write is still asserted. The random phase repeats the window with random snoops between request and response, and compares every line against a reference model.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  localparam int ST_W        = 8;
  localparam int ST_VALID    = 0;
  localparam int ST_WRITABLE = 1;
  localparam int ST_READABLE = 2;
  localparam int ST_DIRTY    = 3;
  localparam int ST_CGE      = 7;

  typedef logic [ST_W-1:0] line_stat_t;

  typedef enum logic {
    KIND_PLAIN = 1'b0,
    KIND_WRINV = 1'b1
  } txn_kind_e;
endpackage

// File: rtl/wlc_promote.sv
module wlc_promote #(
  parameter int LINE_BYTES = 8,
  parameter int OFF_W      = 3,
  parameter int SZ_W       = 2
) (
  input  logic                  en_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [SZ_W-1:0]       size_i,
  output logic                  promote_o,
  output logic [LINE_BYTES-1:0] strb_o
);
  assign promote_o = en_i && (size_i == SZ_W'(OFF_W)) && (off_i == '0);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign strb_o[b] = (b >= int'(off_i)) && (b < int'(off_i) + (1 << size_i));
  end
endmodule

// File: rtl/wlc_kind_fifo.sv
module wlc_kind_fifo import wlc_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  txn_kind_e kind_i,
  input  logic      pop_i,
  output txn_kind_e head_o,
  output logic      full_o,
  output logic      empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  txn_kind_e        kind_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = kind_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) kind_q[i] <= KIND_PLAIN;
    end else begin
      if (push_i) begin
        kind_q[wr_q] <= kind_i;
        wr_q         <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_push_room_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wlc_line.sv
module wlc_line import wlc_pkg::*; #(
  parameter int TAG_W      = 10,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fin_i,
  input  logic [TAG_W-1:0]        fin_tag_i,
  input  logic                    alloc_i,
  input  logic                    upd_i,
  input  logic                    inv_i,
  input  logic [TAG_W-1:0]        wr_tag_i,
  input  logic [8*LINE_BYTES-1:0] wr_data_i,
  input  logic [LINE_BYTES-1:0]   wr_strb_i,
  input  logic                    snp_i,
  input  logic                    snp_inv_i,
  input  logic [TAG_W-1:0]        snp_tag_i,
  output line_stat_t              stat_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [8*LINE_BYTES-1:0] data_o
);
  line_stat_t              stat_q, stat_d;
  logic [TAG_W-1:0]        tag_q, tag_d;
  logic [8*LINE_BYTES-1:0] data_q, data_d;

  always_comb begin
    stat_d = stat_q;
    tag_d  = tag_q;
    data_d = data_q;
    // response closes the owned window; drop if line was lost meanwhile
    if (fin_i && stat_d[ST_VALID] && (tag_d == fin_tag_i)) begin
      if (stat_d[ST_CGE]) stat_d[ST_WRITABLE] = 1'b1;
      stat_d[ST_DIRTY] = 1'b0;
      stat_d[ST_CGE]   = 1'b0;
    end
    if (alloc_i) begin
      stat_d              = '0;
      stat_d[ST_VALID]    = 1'b1;
      stat_d[ST_READABLE] = 1'b1;
      stat_d[ST_DIRTY]    = 1'b1;
      stat_d[ST_CGE]      = 1'b1;
      tag_d               = wr_tag_i;
      data_d              = wr_data_i;
    end
    if (upd_i) begin
      for (int b = 0; b < LINE_BYTES; b++)
        if (wr_strb_i[b]) data_d[8*b +: 8] = wr_data_i[8*b +: 8];
    end
    if (inv_i) stat_d = '0;
    if (snp_i && stat_d[ST_VALID] && (tag_d == snp_tag_i)) begin
      if (snp_inv_i) begin
        stat_d = '0;
      end else begin
        stat_d[ST_WRITABLE] = 1'b0;
        stat_d[ST_CGE]      = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      stat_q <= stat_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign stat_o = stat_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  assert_alloc_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !snp_i |=> stat_q[ST_VALID] && stat_q[ST_DIRTY] && stat_q[ST_CGE]
                          && !stat_q[ST_WRITABLE]);
  assert_cge_owned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[ST_CGE] |-> stat_q[ST_DIRTY] && !stat_q[ST_WRITABLE]);
  assert_fin_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i && stat_q[ST_VALID] && (tag_q == fin_tag_i) && !alloc_i && !inv_i && !snp_i
    |=> !stat_q[ST_DIRTY] && !stat_q[ST_CGE]);
  assert_fin_lost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i && !stat_q[ST_VALID] && !alloc_i && !snp_i |=> $stable(stat_q));
endmodule

// File: rtl/wrinv_line_cache.sv
module wrinv_line_cache import wlc_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int LINE_BYTES  = 8,
  parameter int LINES       = 8,
  parameter int OUTSTANDING = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int DATA_W = 8 * LINE_BYTES,
  localparam int SZ_W   = $clog2(OFF_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_wr_en_i,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [SZ_W-1:0]   cpu_req_size_i,
  input  logic [DATA_W-1:0] cpu_req_data_i,
  output logic              cpu_rsp_valid_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_wrinv_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_data_o,
  output logic [LINE_BYTES-1:0] mem_req_strb_o,
  input  logic              mem_rsp_valid_i,
  input  logic              snp_valid_i,
  input  logic              snp_inv_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              wi_hold_o,
  input  logic [IDX_W-1:0]  stat_idx_i,
  output logic [ST_W-1:0]   stat_o,
  output logic [TAG_W-1:0]  stat_tag_o,
  output logic [DATA_W-1:0] stat_data_o
);
  logic [OFF_W-1:0] cpu_off;
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;

  assign cpu_off = cpu_req_addr_i[OFF_W-1:0];
  assign cpu_idx = cpu_req_addr_i[OFF_W +: IDX_W];
  assign cpu_tag = cpu_req_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr_i[OFF_W +: IDX_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  logic                  promote;
  logic [LINE_BYTES-1:0] strb;

  wlc_promote #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_promote (
    .en_i     (fast_wr_en_i),
    .off_i    (cpu_off),
    .size_i   (cpu_req_size_i),
    .promote_o(promote),
    .strb_o   (strb)
  );

  line_stat_t        st_a   [LINES];
  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  line_stat_t cur_st;
  logic       hit;
  assign cur_st = st_a[cpu_idx];
  assign hit    = cur_st[ST_VALID] && (tag_a[cpu_idx] == cpu_tag);

  // transaction order and pending write-invalidate
  txn_kind_e        head_kind;
  logic             fifo_full, fifo_empty;
  logic             wi_pend_q, hold_q, rsp_q;
  logic [IDX_W-1:0] wi_idx_q;
  logic [TAG_W-1:0] wi_tag_q;
  logic             wi_done;

  assign wi_done = mem_rsp_valid_i && (head_kind == KIND_WRINV);

  logic wi_block, slot_free, acc;
  logic ev_alloc, ev_upd, ev_inv;
  logic mreq_v_q;

  assign wi_block  = promote ? (wi_pend_q || cur_st[ST_DIRTY])
                             : (hit && cur_st[ST_CGE]);
  assign slot_free = !mreq_v_q && !fifo_full;
  assign cpu_req_ready_o = slot_free && !wi_block;
  assign acc      = cpu_req_valid_i && cpu_req_ready_o;
  assign ev_alloc = acc && promote;
  assign ev_upd   = acc && !promote && hit && cur_st[ST_WRITABLE];
  assign ev_inv   = acc && !promote && hit && !cur_st[ST_WRITABLE];

  wlc_kind_fifo #(.DEPTH(OUTSTANDING)) u_order (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (acc),
    .kind_i (promote ? KIND_WRINV : KIND_PLAIN),
    .pop_i  (mem_rsp_valid_i),
    .head_o (head_kind),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    wlc_line #(.TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fin_i    (wi_done && (wi_idx_q == IDX_W'(i))),
      .fin_tag_i(wi_tag_q),
      .alloc_i  (ev_alloc && (cpu_idx == IDX_W'(i))),
      .upd_i    (ev_upd && (cpu_idx == IDX_W'(i))),
      .inv_i    (ev_inv && (cpu_idx == IDX_W'(i))),
      .wr_tag_i (cpu_tag),
      .wr_data_i(cpu_req_data_i),
      .wr_strb_i(strb),
      .snp_i    (snp_valid_i && (snp_idx == IDX_W'(i))),
      .snp_inv_i(snp_inv_i),
      .snp_tag_i(snp_tag),
      .stat_o   (st_a[i]),
      .tag_o    (tag_a[i]),
      .data_o   (data_a[i])
    );
  end

  logic                  mreq_wi_q;
  logic [ADDR_W-1:0]     mreq_addr_q;
  logic [DATA_W-1:0]     mreq_data_q;
  logic [LINE_BYTES-1:0] mreq_strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mreq_v_q    <= 1'b0;
      mreq_wi_q   <= 1'b0;
      mreq_addr_q <= '0;
      mreq_data_q <= '0;
      mreq_strb_q <= '0;
    end else if (acc) begin
      mreq_v_q    <= 1'b1;
      mreq_wi_q   <= promote;
      mreq_addr_q <= cpu_req_addr_i;
      mreq_data_q <= cpu_req_data_i;
      mreq_strb_q <= strb;
    end else if (mem_req_ready_i) begin
      mreq_v_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wi_pend_q <= 1'b0;
      wi_idx_q  <= '0;
      wi_tag_q  <= '0;
      hold_q    <= 1'b0;
      rsp_q     <= 1'b0;
    end else begin
      rsp_q <= mem_rsp_valid_i;
      if (ev_alloc) begin
        wi_pend_q <= 1'b1;
        wi_idx_q  <= cpu_idx;
        wi_tag_q  <= cpu_tag;
      end else if (wi_done) begin
        wi_pend_q <= 1'b0;
      end
      // release wins so a stalled writer is not left waiting
      if (wi_done)                          hold_q <= 1'b0;
      else if (cpu_req_valid_i && wi_block) hold_q <= 1'b1;
    end
  end

  assign mem_req_valid_o = mreq_v_q;
  assign mem_req_wrinv_o = mreq_wi_q;
  assign mem_req_addr_o  = mreq_addr_q;
  assign mem_req_data_o  = mreq_data_q;
  assign mem_req_strb_o  = mreq_strb_q;
  assign cpu_rsp_valid_o = rsp_q;
  assign wi_hold_o       = hold_q;
  assign stat_o          = st_a[stat_idx_i];
  assign stat_tag_o      = tag_a[stat_idx_i];
  assign stat_data_o     = data_a[stat_idx_i];

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i
    |=> mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_data_o));
  assert_rsp_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |=> cpu_rsp_valid_o);
  assert_hold_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wi_done |=> !wi_hold_o);
  assert_wi_tracked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wi_pend_q |-> !fifo_empty);
endmodule

// File: tb/tb_wrinv_line_cache.sv
`timescale 1ns/1ps
module tb_wrinv_line_cache;
  localparam int ADDR_W = 16;
  localparam int LB     = 8;
  localparam int LINES  = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fast_wr_en_i = 1'b0;
  logic        cpu_req_valid_i = 1'b0;
  logic        cpu_req_ready_o;
  logic [15:0] cpu_req_addr_i = '0;
  logic [1:0]  cpu_req_size_i = '0;
  logic [63:0] cpu_req_data_i = '0;
  logic        cpu_rsp_valid_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b1;
  logic        mem_req_wrinv_o;
  logic [15:0] mem_req_addr_o;
  logic [63:0] mem_req_data_o;
  logic [7:0]  mem_req_strb_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        snp_valid_i = 1'b0;
  logic        snp_inv_i = 1'b0;
  logic [15:0] snp_addr_i = '0;
  logic        wi_hold_o;
  logic [2:0]  stat_idx_i = '0;
  logic [7:0]  stat_o;
  logic [9:0]  stat_tag_o;
  logic [63:0] stat_data_o;

  always #5 clk_i = ~clk_i;

  wrinv_line_cache dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  m_st   [LINES];
  logic [9:0]  m_tag  [LINES];
  logic [63:0] m_data [LINES];
  bit          m_pend;
  logic [2:0]  m_pidx;
  logic [9:0]  m_ptag;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [9:0] t, input logic [2:0] i, input logic [2:0] o);
    return {t, i, o};
  endfunction

  function automatic logic [7:0] e_strb(input logic [1:0] sz, input logic [2:0] o);
    logic [7:0] s;
    for (int b = 0; b < LB; b++) s[b] = (b >= int'(o)) && (b < int'(o) + (1 << sz));
    return s;
  endfunction

  function automatic bit e_prom(input bit fen, input logic [1:0] sz, input logic [2:0] o);
    return fen && (sz == 2'd3) && (o == 3'd0);
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] d, input bit fen);
    logic [2:0] i; logic [9:0] t; logic [7:0] s;
    i = a[5:3]; t = a[15:6];
    if (e_prom(fen, sz, a[2:0])) begin
      m_st[i] = 8'h8D; m_tag[i] = t; m_data[i] = d;
      m_pend = 1; m_pidx = i; m_ptag = t;
    end else if (m_st[i][0] && m_tag[i] == t) begin
      if (m_st[i][1]) begin
        s = e_strb(sz, a[2:0]);
        for (int b = 0; b < LB; b++) if (s[b]) m_data[i][8*b +: 8] = d[8*b +: 8];
      end else m_st[i] = 8'h00;
    end
  endtask

  task automatic m_snoop(input logic [15:0] a, input bit inv);
    logic [2:0] i;
    i = a[5:3];
    if (m_st[i][0] && m_tag[i] == a[15:6]) begin
      if (inv) m_st[i] = 8'h00;
      else m_st[i] = m_st[i] & ~8'h82;
    end
  endtask

  task automatic m_finish();
    bit cge;
    if (m_pend) begin
      if (m_st[m_pidx][0] && m_tag[m_pidx] == m_ptag) begin
        cge = m_st[m_pidx][7];
        m_st[m_pidx] = m_st[m_pidx] & ~8'h88;
        if (cge) m_st[m_pidx] = m_st[m_pidx] | 8'h02;
      end
      m_pend = 0;
    end
  endtask

  task automatic check_lines(input string req);
    for (int i = 0; i < LINES; i++) begin
      stat_idx_i = 3'(i);
      #1;
      chk({req, " status"}, stat_o, m_st[i]);
      if (m_st[i][0]) begin
        chk({req, " tag"}, stat_tag_o, m_tag[i]);
        chk({req, " data"}, stat_data_o, m_data[i]);
      end
    end
  endtask

  // drive a write until accepted; returns at the negedge after acceptance
  task automatic cpu_wr(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] d,
                        input bit fen, output bit ok);
    int k;
    @(negedge clk_i);
    cpu_req_valid_i = 1; cpu_req_addr_i = a; cpu_req_size_i = sz;
    cpu_req_data_i = d; fast_wr_en_i = fen;
    #1;
    k = 0;
    while (!cpu_req_ready_o && k < 50) begin
      @(negedge clk_i); #1; k++;
    end
    ok = cpu_req_ready_o;
    if (ok) @(posedge clk_i);
    @(negedge clk_i);
    cpu_req_valid_i = 0;
    #1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] d,
                          input bit fen);
    bit ok;
    cpu_wr(a, sz, d, fen, ok);
    chk("R3 write accepted", ok, 1);
    chk("R3 mem request valid", mem_req_valid_o, 1);
    chk("R3 mem request addr", mem_req_addr_o, a);
    chk("R1 wrinv kind", mem_req_wrinv_o, e_prom(fen, sz, a[2:0]));
    chk("R1 strobes", mem_req_strb_o, e_strb(sz, a[2:0]));
    if (ok) m_write(a, sz, d, fen);
  endtask

  task automatic rsp_one();
    @(negedge clk_i); mem_rsp_valid_i = 1;
    @(negedge clk_i); mem_rsp_valid_i = 0;
    #1;
    chk("R8 cpu response", cpu_rsp_valid_o, 1);
  endtask

  task automatic snoop(input logic [15:0] a, input bit inv);
    @(negedge clk_i); snp_valid_i = 1; snp_addr_i = a; snp_inv_i = inv;
    @(negedge clk_i); snp_valid_i = 0;
    #1;
    m_snoop(a, inv);
  endtask

  localparam logic [9:0] TA = 10'h015;
  localparam logic [9:0] TB = 10'h2A3;

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
    m_pend = 0; m_pidx = 0; m_ptag = 0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R11 hold reset", wi_hold_o, 0);
    chk("R11 mem valid reset", mem_req_valid_o, 0);
    chk("R11 rsp reset", cpu_rsp_valid_o, 0);
    check_lines("R11 reset");
    @(negedge clk_i); rst_ni = 1;

    // full-line write with fast writes off: plain, no allocation
    do_write(mk(TA, 3'd1, 3'd0), 2'd3, 64'h1111_2222_3333_4444, 0);
    rsp_one();
    check_lines("R10 miss untouched");

    // promoted write, then refusals inside the window
    do_write(mk(TA, 3'd2, 3'd0), 2'd3, 64'hA5A5_0102_0304_0506, 1);
    check_lines("R2 allocate");
    @(negedge clk_i);
    cpu_req_valid_i = 1; cpu_req_addr_i = mk(TB, 3'd5, 3'd0); cpu_req_size_i = 3;
    fast_wr_en_i = 1; #1;
    chk("R4 second full-line refused", cpu_req_ready_o, 0);
    @(negedge clk_i); #1;
    chk("R4 still refused", cpu_req_ready_o, 0);
    chk("R4 nothing forwarded", mem_req_valid_o, 0);
    chk("R7 hold raised", wi_hold_o, 1);
    cpu_req_valid_i = 0;
    do_write(mk(TB, 3'd6, 3'd1), 2'd0, 64'h0000_0000_0000_7700, 1);
    @(negedge clk_i);
    cpu_req_valid_i = 1; cpu_req_addr_i = mk(TA, 3'd2, 3'd4); cpu_req_size_i = 2;
    cpu_req_data_i = 64'hDEAD_BEEF_0000_0000; fast_wr_en_i = 1; #1;
    chk("R7 plain write to owned line refused", cpu_req_ready_o, 0);
    @(negedge clk_i); #1;
    chk("R7 still refused", cpu_req_ready_o, 0);
    chk("R7 hold set", wi_hold_o, 1);
    mem_rsp_valid_i = 1;
    @(negedge clk_i); mem_rsp_valid_i = 0; #1;
    chk("R8 cpu response for wrinv", cpu_rsp_valid_o, 1);
    chk("R7 hold released", wi_hold_o, 0);
    chk("R7 stalled write now ready", cpu_req_ready_o, 1);
    m_finish();
    stat_idx_i = 3'd2; #1;
    chk("R5 exclusive after response", stat_o, 8'h07);
    @(posedge clk_i);
    @(negedge clk_i); cpu_req_valid_i = 0; #1;
    m_write(mk(TA, 3'd2, 3'd4), 2'd2, 64'hDEAD_BEEF_0000_0000, 1);
    chk("R1 merge write is plain", mem_req_wrinv_o, 0);
    check_lines("R10 merge into writable");
    stat_idx_i = 3'd2; #1;
    chk("R10 merged data", stat_data_o, 64'hDEAD_BEEF_0304_0506);
    rsp_one();
    rsp_one();

    // snoop read inside window gives shared
    do_write(mk(TB, 3'd3, 3'd0), 2'd3, 64'h0F0F_0F0F_F0F0_F0F0, 1);
    snoop(mk(TB, 3'd3, 3'd0), 0);
    stat_idx_i = 3'd3; #1;
    chk("R6 snoop read clears W and CGE", stat_o, 8'h0D);
    rsp_one(); m_finish();
    stat_idx_i = 3'd3; #1;
    chk("R5 shared after response", stat_o, 8'h05);
    do_write(mk(TB, 3'd3, 3'd2), 2'd1, 64'h0000_0000_0000_1200, 0);
    check_lines("R10 shared hit invalidates");
    rsp_one();

    // invalidate inside window: response ignored
    do_write(mk(TA, 3'd4, 3'd0), 2'd3, 64'h7777_8888_9999_AAAA, 1);
    snoop(mk(TA, 3'd4, 3'd0), 1);
    check_lines("R6 snoop invalidate");
    rsp_one(); m_finish();
    check_lines("R9 response after eviction");
    snoop(mk(TB, 3'd2, 3'd0), 1);
    check_lines("R6 snoop tag miss no effect");

    // partial writes are not promoted
    do_write(mk(TA, 3'd0, 3'd4), 2'd2, 64'h1234_5678_0000_0000, 1);
    rsp_one();
    do_write(mk(TA, 3'd0, 3'd0), 2'd2, 64'h0000_0000_8765_4321, 1);
    rsp_one();

    // memory backpressure
    mem_req_ready_i = 0;
    do_write(mk(TB, 3'd7, 3'd0), 2'd3, 64'hCAFE_0000_0000_0001, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); #1;
      chk("R3 held under backpressure", mem_req_valid_o, 1);
      chk("R3 addr stable", mem_req_addr_o, mk(TB, 3'd7, 3'd0));
    end
    mem_req_ready_i = 1;
    @(negedge clk_i); #1;
    chk("R3 single request", mem_req_valid_o, 0);
    rsp_one(); m_finish();
    check_lines("R5 after backpressure");

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [2:0] ri; logic [9:0] rt; logic [1:0] rs; logic [2:0] ro; bit rf;
      logic [63:0] rd;
      ri = 3'($urandom % LINES);
      rt = ($urandom % 2) ? TA : TB;
      rs = 2'($urandom % 4);
      if ($urandom % 3 == 0) rs = 2'd3;
      ro = 3'((($urandom % (LB >> rs))) << rs);
      rf = ($urandom % 4) != 0;
      rd = {$urandom, $urandom};
      do_write(mk(rt, ri, ro), rs, rd, rf);
      if ($urandom % 3 == 0)
        snoop(mk((($urandom % 2) ? TA : TB), ri, 3'd0), bit'($urandom % 2));
      rsp_one(); m_finish();
      check_lines("R5 R6 R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule